// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for the two-wire PHY management bus. Software configures it through a 32-bit register port. It then runs clause-22 read and write frames to external PHYs. A config register holds a clock divider and an enable bit. A write-data register holds the value for a write. A control register takes the command and shows an idle flag. A read-data register returns what was sampled during a read. A fifth register is plain storage that has no effect on the block.

A write goes like this. Software loads the write-data register, then writes the control word with the operation, PHY address, register address and the start bit set. It then polls the ready bit until the frame ends. A read is the same, except that software collects the result from the read-data register once ready is 1 again. The block drives the management clock and the data line, together with an output enable for an external tri-state pad. It samples the incoming data line on the rising edge of the management clock.

Top module: `mmc_top`

## Requirements
- R1: After reset, all five registers read 0 (config 0x00, control 0x04, read data 0x08, write data 0x0C, spare 0x10). mdc_o is low, mdio_oe_o is low and mdio_o is 1.
- R2: Config bits [7:0] hold the divider and bit 8 is the enable; the register reads back {23'b0, en, div}. Control bit 0 (ready) reads 1 only while enable is 1 and no frame is running.
- R3: Each half-period of mdc_o lasts div+1 clock cycles. A frame takes 64 full MDC periods, so ready reads 1 again exactly 128*(div+1) clock edges after the edge that captured the start.
- R4: A start has control bit 8 set, opcode in [31:30] (2'b01 write, 2'b10 read), PHY address in [28:24] and register address in [20:16]. The start is accepted only when enable is 1, no frame is running and the opcode is 01 or 10. Any other start is ignored: no MDC activity, and the control fields stay unchanged.
- R5: The control register reads back the opcode in [31:30], PHY address in [28:24] and register address in [20:16] of the last accepted start. Bit 8 always reads 0, and all other bits except ready read 0.
- R6: A frame is sent MSB first as 32 ones, then 01, the opcode, the 5-bit PHY address, the 5-bit register address, a 2-bit turnaround and 16 data bits. mdio_o changes only while mdc_o is low and holds steady across each high phase.
- R7: A write frame drives every bit (mdio_oe_o high for the whole frame) and sends turnaround 10. Its 16 data bits are the write-data register as it stood when the start was accepted; later writes to that register do not change the frame in flight.
- R8: A read frame releases the line (mdio_oe_o low) for the last 18 bits, which are the turnaround and the data. It samples mdio_i on the rising edges of MDC 49 to 64 and, when the frame ends, places the 16 bits in read-data [15:0] with [31:16] zero.
- R9: Clearing enable during a frame aborts it. From the following cycle, mdc_o is low, mdio_oe_o is low and ready reads 0. After enable is set again, ready reads 1 and a new frame runs normally.
- R10: Bus writes to the read-data register are ignored. The write-data register keeps bits [15:0] and reads [31:16] as 0. The spare register at 0x10 reads back all 32 bits written and has no other effect.
- R11: While no frame is running, mdc_o stays low, mdio_oe_o is low and mdio_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 5 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for the data pad |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
A vector table mixes write and read frames. The PHY and register addresses cover 0, 31 and alternating bit patterns, and the data runs from all-zeros and all-ones to single-bit values. The dividers range from 0 to 4. Captured frame bits at each MDC rising edge separate field-order and bit-order faults. The output-enable mask separates read from write turnaround handling. The exact cycle count to ready separates off-by-one faults in the divider from faults in the frame length. Directed cases cover starts while disabled, while busy and with invalid opcodes, a change to the write data mid-frame, and an abort by clearing enable. Each of these shows whether a stray command leaks into the frame on the wire.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
  localparam int unsigned BUS_AW  = 5;
  localparam int unsigned BUS_DW  = 32;
  localparam int unsigned DIV_W   = 8;
  localparam int unsigned PA_W    = 5;
  localparam int unsigned RA_W    = 5;
  localparam int unsigned MD_DW   = 16;
  localparam int unsigned PRE_LEN = 32;
  localparam int unsigned FRM_LEN = PRE_LEN + 2 + 2 + PA_W + RA_W + 2 + MD_DW;
  localparam int unsigned IDX_W   = $clog2(FRM_LEN);
  localparam int unsigned TA_IDX  = FRM_LEN - MD_DW - 2;
  localparam int unsigned DAT_IDX = FRM_LEN - MD_DW;

  localparam logic [BUS_AW-1:0] A_CFG  = 5'h00;
  localparam logic [BUS_AW-1:0] A_CTRL = 5'h04;
  localparam logic [BUS_AW-1:0] A_RDAT = 5'h08;
  localparam logic [BUS_AW-1:0] A_WDAT = 5'h0C;
  localparam logic [BUS_AW-1:0] A_SPARE = 5'h10;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_BAD  = 2'b11
  } mmc_op_e;

  typedef struct packed {
    mmc_op_e           op;
    logic [PA_W-1:0]   phy;
    logic [RA_W-1:0]   regad;
    logic [MD_DW-1:0]  data;
  } mmc_cmd_t;
endpackage

// File: rtl/mmc_regs.sv
module mmc_regs
  import mmc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [BUS_DW-1:0] wdata_i,
  output logic [BUS_DW-1:0] rdata_o,
  input  logic              busy_i,
  input  logic [MD_DW-1:0]  rd_data_i,
  output logic              cfg_en_o,
  output logic [DIV_W-1:0]  cfg_div_o,
  output logic              start_o,
  output mmc_cmd_t          cmd_o
);
  logic [DIV_W-1:0] div_q;
  logic             en_q;
  logic [MD_DW-1:0] wdat_q;
  logic [BUS_DW-1:0] spare_q;
  mmc_op_e          op_q;
  logic [PA_W-1:0]  phy_q;
  logic [RA_W-1:0]  reg_q;
  mmc_op_e          op_in;
  logic             op_ok;

  assign op_in = mmc_op_e'(wdata_i[31:30]);
  assign op_ok = (op_in == OP_WR) || (op_in == OP_RD);
  assign start_o = wr_i && (addr_i == A_CTRL) && wdata_i[8] && en_q && !busy_i && op_ok;

  assign cmd_o.op    = op_in;
  assign cmd_o.phy   = wdata_i[28:24];
  assign cmd_o.regad = wdata_i[20:16];
  assign cmd_o.data  = wdat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      en_q    <= 1'b0;
      wdat_q  <= '0;
      spare_q <= '0;
      op_q    <= OP_NONE;
      phy_q   <= '0;
      reg_q   <= '0;
    end else begin
      if (wr_i && addr_i == A_CFG) begin
        div_q <= wdata_i[DIV_W-1:0];
        en_q  <= wdata_i[DIV_W];
      end
      if (wr_i && addr_i == A_WDAT) wdat_q <= wdata_i[MD_DW-1:0];
      if (wr_i && addr_i == A_SPARE) spare_q <= wdata_i;
      if (start_o) begin
        op_q  <= cmd_o.op;
        phy_q <= cmd_o.phy;
        reg_q <= cmd_o.regad;
      end
    end
  end

  assign cfg_en_o  = en_q;
  assign cfg_div_o = div_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CFG:   rdata_o = {{(BUS_DW-DIV_W-1){1'b0}}, en_q, div_q};
      A_CTRL:  rdata_o = {op_q, 1'b0, phy_q, 3'b0, reg_q, 15'b0, en_q & ~busy_i};
      A_RDAT:  rdata_o = {{(BUS_DW-MD_DW){1'b0}}, rd_data_i};
      A_WDAT:  rdata_o = {{(BUS_DW-MD_DW){1'b0}}, wdat_q};
      A_SPARE: rdata_o = spare_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mmc_clkgen.sv
module mmc_clkgen
  import mmc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick   = en_i && run_i && (cnt_q == div_i);
  assign rise_o = tick && !mdc_o;
  assign fall_o = tick && mdc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (!en_i || !run_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mmc_frame.sv
module mmc_frame
  import mmc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  mmc_cmd_t         cmd_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             mdio_i,
  output logic             busy_o,
  output logic             is_rd_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  output logic [MD_DW-1:0] rd_data_o
);
  logic [FRM_LEN-1:0] sh_q;
  logic [IDX_W-1:0]   idx_q;
  logic [MD_DW-1:0]   rx_q;
  logic [FRM_LEN-1:0] frame_w;
  logic               rd_cmd;

  assign rd_cmd  = (cmd_i.op == OP_RD);
  assign frame_w = {{PRE_LEN{1'b1}}, 2'b01, cmd_i.op, cmd_i.phy, cmd_i.regad,
                    rd_cmd ? 2'b11 : 2'b10,
                    rd_cmd ? {MD_DW{1'b1}} : cmd_i.data};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      is_rd_o   <= 1'b0;
      idx_q     <= '0;
      sh_q      <= '0;
      rx_q      <= '0;
      rd_data_o <= '0;
    end else if (!en_i) begin
      busy_o <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_o  <= 1'b1;
      is_rd_o <= rd_cmd;
      idx_q   <= '0;
      sh_q    <= frame_w;
    end else if (busy_o) begin
      if (rise_i && is_rd_o && idx_q >= IDX_W'(DAT_IDX))
        rx_q <= {rx_q[MD_DW-2:0], mdio_i};
      if (fall_i) begin
        if (idx_q == IDX_W'(FRM_LEN - 1)) begin
          busy_o <= 1'b0;
          if (is_rd_o) rd_data_o <= rx_q;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRM_LEN-2:0], 1'b1};
        end
      end
    end
  end

  assign mdio_o    = busy_o ? sh_q[FRM_LEN-1] : 1'b1;
  assign mdio_oe_o = busy_o && (!is_rd_o || idx_q < IDX_W'(TA_IDX));
endmodule

// File: rtl/mmc_top.sv
module mmc_top
  import mmc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic [BUS_DW-1:0] bus_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic             cfg_en;
  logic [DIV_W-1:0] cfg_div;
  logic             start_go;
  mmc_cmd_t         cmd;
  logic             busy;
  logic             is_rd;
  logic             mdc_rise;
  logic             mdc_fall;
  logic [MD_DW-1:0] rd_data;

  mmc_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .busy_i    (busy),
    .rd_data_i (rd_data),
    .cfg_en_o  (cfg_en),
    .cfg_div_o (cfg_div),
    .start_o   (start_go),
    .cmd_o     (cmd)
  );

  mmc_clkgen u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_en),
    .run_i  (busy),
    .div_i  (cfg_div),
    .mdc_o  (mdc_o),
    .rise_o (mdc_rise),
    .fall_o (mdc_fall)
  );

  mmc_frame u_frm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cfg_en),
    .start_i   (start_go),
    .cmd_i     (cmd),
    .rise_i    (mdc_rise),
    .fall_i    (mdc_fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .is_rd_o   (is_rd),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/mmc_chk.sv
module mmc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_en,
  input logic busy,
  input logic is_rd,
  input logic start_go,
  input logic mdc_o,
  input logic mdio_o,
  input logic mdio_oe_o
);
  a_r9_disable_stops_mdc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en |=> !mdc_o);

  a_r4_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(start_go));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mdc_o && !mdio_oe_o && mdio_o));

  a_r3_mdc_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o != $past(mdc_o)) |-> $past(busy));

  a_r6_data_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && mdc_o && $past(mdc_o)) |-> $stable(mdio_o));

  a_r8_release_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $fell(mdio_oe_o)) |-> is_rd);
endmodule

bind mmc_top mmc_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_en    (cfg_en),
  .busy      (busy),
  .is_rd     (is_rd),
  .start_go  (start_go),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mmc_top_tb.sv
module mmc_top_tb_top;
  localparam int CLK_PER = 10;
  localparam int NVEC = 6;
  // {op, phy, reg, data, div}
  localparam logic [35:0] VEC [NVEC] = '{
    {2'b01, 5'd1,  5'd0,  16'hA5C3, 8'd0},
    {2'b10, 5'd31, 5'd2,  16'h1234, 8'd1},
    {2'b01, 5'd16, 5'd31, 16'hFFFF, 8'd2},
    {2'b10, 5'd0,  5'd17, 16'h0001, 8'd0},
    {2'b01, 5'd21, 5'd10, 16'h0000, 8'd1},
    {2'b10, 5'd10, 5'd21, 16'h8000, 8'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int rise_cnt = 0, rise_base = 0;
  logic [63:0] cap_bits = '0, cap_oe = '0;
  logic [15:0] rd_pat = '0;

  always #(CLK_PER/2) clk = ~clk;

  mmc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // PHY model: capture on MDC rise, drive read data for rises 48..63
  always @(posedge mdc) begin
    cap_bits <= {cap_bits[62:0], mdio_out};
    cap_oe   <= {cap_oe[62:0], mdio_oe};
    rise_cnt <= rise_cnt + 1;
  end
  always_comb begin
    int k;
    k = rise_cnt - rise_base;
    mdio_in = (k >= 48 && k < 64) ? rd_pat[63-k] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r);
    return {op, 1'b0, p, 3'b0, r, 7'b0, 1'b1, 8'b0};
  endfunction

  task automatic wait_ready(output int n);
    logic [31:0] v;
    n = 0;
    rd(5'h04, v);
    while (!v[0] && n < 100000) begin
      @(negedge clk);
      n++;
      rd(5'h04, v);
    end
  endtask

  initial begin
    #(CLK_PER * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] exp;
    int n, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(5'(a * 4), v);
      chk(v == 0, "R1 reg reset", 64'(v), 64'h0);
    end
    chk(!mdc && !mdio_oe && mdio_out, "R1 pins reset", {61'b0, mdc, mdio_oe, mdio_out}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 start while disabled is ignored
    r0 = rise_cnt;
    wr(5'h04, ctl(2'b01, 5'd3, 5'd4));
    repeat (300) @(negedge clk);
    chk(rise_cnt == r0, "R4 no mdc when disabled", 64'(rise_cnt), 64'(r0));
    rd(5'h04, v);
    chk(v == 0, "R4 ctrl untouched when disabled", 64'(v), 64'h0);

    // R2 config readback and ready
    wr(5'h00, 32'h0000_0102);
    rd(5'h00, v);
    chk(v == 32'h102, "R2 cfg readback", 64'(v), 64'h102);
    rd(5'h04, v);
    chk(v[0] == 1'b1, "R2 ready when enabled idle", 64'(v[0]), 64'h1);

    // R4 invalid opcode ignored
    r0 = rise_cnt;
    wr(5'h04, ctl(2'b11, 5'd7, 5'd7));
    repeat (50) @(negedge clk);
    rd(5'h04, v);
    chk(v == 32'h1 && rise_cnt == r0, "R4 bad op ignored", 64'(v), 64'h1);

    // table walk: R3 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op; logic [4:0] p, r; logic [15:0] d; logic [7:0] dv;
      {op, p, r, d, dv} = VEC[i];
      wr(5'h00, {23'b0, 1'b1, dv});
      if (op == 2'b01) wr(5'h0C, {16'hDEAD, d});
      rd_pat = d;
      rise_base = rise_cnt;
      wr(5'h04, ctl(op, p, r));
      rd(5'h04, v);
      chk(v[0] == 1'b0, "R2 ready low in flight", 64'(v[0]), 64'h0);
      chk(v == {op, 1'b0, p, 3'b0, r, 16'b0}, "R5 ctrl readback", 64'(v), 64'({op, 1'b0, p, 3'b0, r, 16'b0}));
      wait_ready(n);
      chk(n == 128 * (dv + 1), "R3 frame duration", 64'(n), 64'(128 * (dv + 1)));
      exp = {32'hFFFF_FFFF, 2'b01, op, p, r, 2'b10, d};
      if (op == 2'b01) begin
        chk(cap_bits == exp, "R6 R7 write frame bits", cap_bits, exp);
        chk(cap_oe == '1, "R7 write drives all", cap_oe, '1);
      end else begin
        chk(cap_bits[63:18] == exp[63:18], "R6 read header bits", 64'(cap_bits[63:18]), 64'(exp[63:18]));
        chk(cap_oe == {{46{1'b1}}, 18'b0}, "R8 read release mask", cap_oe, {{46{1'b1}}, 18'b0});
        rd(5'h08, v);
        chk(v == {16'b0, d}, "R8 read data", 64'(v), 64'(d));
      end
      chk(!mdc && !mdio_oe && mdio_out, "R11 idle pins", {61'b0, mdc, mdio_oe, mdio_out}, 64'h1);
    end

    // R4 start while busy ignored, R7 mid-frame wdata change ignored
    wr(5'h00, 32'h0000_0100);
    wr(5'h0C, 32'h0000_3C5A);
    wr(5'h04, ctl(2'b01, 5'd9, 5'd6));
    repeat (10) @(negedge clk);
    wr(5'h0C, 32'h0000_FFFF);
    wr(5'h04, ctl(2'b10, 5'd2, 5'd2));
    wait_ready(n);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd9, 5'd6, 2'b10, 16'h3C5A};
    chk(cap_bits == exp, "R4 R7 busy start and wdata change ignored", cap_bits, exp);
    rd(5'h04, v);
    chk(v[31:16] == {2'b01, 1'b0, 5'd9, 3'b0, 5'd6}, "R5 fields kept", 64'(v[31:16]), 64'({2'b01, 1'b0, 5'd9, 3'b0, 5'd6}));

    // R9 abort by clearing enable
    wr(5'h00, 32'h0000_0101);
    wr(5'h04, ctl(2'b01, 5'd1, 5'd1));
    repeat (40) @(negedge clk);
    wr(5'h00, 32'h0000_0001);
    @(negedge clk);
    rd(5'h04, v);
    chk(!mdc && !mdio_oe && v[0] == 1'b0, "R9 abort quiet", {61'b0, mdc, mdio_oe, v[0]}, 64'h0);
    r0 = rise_cnt;
    repeat (100) @(negedge clk);
    chk(rise_cnt == r0, "R9 no mdc after abort", 64'(rise_cnt), 64'(r0));
    wr(5'h00, 32'h0000_0100);
    rd(5'h04, v);
    chk(v[0] == 1'b1, "R9 ready after reenable", 64'(v[0]), 64'h1);
    wr(5'h0C, 32'h0000_0F0F);
    wr(5'h04, ctl(2'b01, 5'd4, 5'd8));
    wait_ready(n);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd4, 5'd8, 2'b10, 16'h0F0F};
    chk(n == 128 && cap_bits == exp, "R9 frame after abort", cap_bits, exp);

    // R10 register behaviour
    rd(5'h08, v);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, exp[31:0]);
    chk(exp[31:0] == v, "R10 rdata not writable", 64'(exp[31:0]), 64'(v));
    wr(5'h0C, 32'hABCD_1357);
    rd(5'h0C, v);
    chk(v == 32'h0000_1357, "R10 wdata width", 64'(v), 64'h1357);
    wr(5'h10, 32'hCAFE_F00D);
    rd(5'h10, v);
    chk(v == 32'hCAFE_F00D, "R10 spare storage", 64'(v), 64'hCAFEF00D);
    rd(5'h04, v);
    chk(v[0] == 1'b1 && !mdc, "R10 spare no effect", 64'(v[0]), 64'h1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule